// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that lets a host controller read and write a small bank of 8-bit control registers. The clock and data lines are brought in as plain inputs and re-timed onto the system clock. The block can only pull the data line low; the board supplies the pull-up. A fixed 7-bit device address selects the slave. The direction bit that follows the address picks a write or a read.

After the address, a command byte sets the transfer mode and the starting register. In block mode the host sends a byte count and then that many data bytes, and the register index advances after each byte. A block read starts with a repeated start and the read address; the slave returns a byte count and then the register contents. In byte mode one register is written, or one register is returned. The stored bits drive output-enable, drive-strength and clock-stop controls in nearby logic. Some bit positions are fixed and cannot be changed. One bit is a computed status flag that shows whether the stoppable clocks are running.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges only the address bytes 0xD2 (write) and 0xD3 (read). After any other address byte it leaves SDA released for the rest of that transfer, and no register changes.
- R2: A start condition (SDA falls while SCL is high) or a stop condition (SDA rises while SCL is high) releases SDA. A stop in the middle of a byte aborts the transfer, and the partial byte is not written. The next transfer then works normally.
- R3: In the command byte, bit 7 = 1 selects byte mode and bit 7 = 0 selects block mode. Bits 6:0 give the starting register index, reduced modulo NUM_REGS.
- R4: In a block write, the byte after the command is a count N. The next N data bytes are stored at the index, which rises by one per byte and wraps from the last register to register 0. Data bytes beyond N are NACKed and not stored.
- R5: In a byte write, one data byte is stored at the index. Any further data byte in the same transfer is NACKed and not stored.
- R6: A block read (command, repeated start, 0xD3) returns a count byte equal to NUM_REGS. It then returns registers from the index upward, wrapping, for as long as the host acknowledges.
- R7: A byte read (byte-mode command, repeated start, 0xD3) returns the register at the index.
- R8: When the host NACKs a byte the slave sent, the slave keeps SDA released until the next start condition.
- R9: Fixed bits ignore writes. Register 0 bit 7 reads 0, register 1 bit 6 reads 1, and register 2 bits 1:0 read 0.
- R10: Register 0 bit 3 is a read-only status bit. It reads 1 only when register 0 bit 2 (clock-stop control, 0 = stop) is 1 and the pci_stop_ni input is high; otherwise it reads 0. It is held as 0 in regs_o.
- R11: After reset, every writable bit is 1. Register values on the bus are then 0x7F, 0xFF, 0xFC, 0xFF, 0xFF, 0xFF, 0xFF, 0xFF for registers 0 to 7, with pci_stop_ni high.
- R12: The slave pulls SDA low during the acknowledge clock of every byte it accepts. It changes its SDA drive only while SCL is low, except for the release on a start or stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the bus, asynchronous |
| pci_stop_ni | input | 1 | External clock-stop request, active low |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| regs_o | output | NUM_REGS*8 | Stored register contents, register 0 in the low byte |

## Verification
The bench uses the default parameters: eight registers, device address 0x69 and two synchronizer stages. With a 3-bit index, a block transfer of four bytes from register 6 crosses the wrap from register 7 to register 0. Command indexes such as 0x0D show the modulo fold onto register 5. The bus is driven at six system clocks per quarter bit, which leaves room for the synchronizer delay. A block read of all eight registers fits easily in the run, so the whole bank, including the fixed and status bits, can be compared after reset and after random traffic.

// File: rtl/smb_cfg_pkg.sv
`timescale 1ns/1ps
package smb_cfg_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RX_ACK, S_TX, S_TX_ACK, S_SKIP
  } smb_state_e;

  typedef enum logic [1:0] {
    ROLE_ADDR, ROLE_CMD, ROLE_CNT, ROLE_DATA
  } smb_role_e;
endpackage

// File: rtl/smb_line_sync.sv
`timescale 1ns/1ps
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  // idle bus level is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/smb_bus_events.sv
`timescale 1ns/1ps
module smb_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // conditions need SCL high on both samples
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/smb_reg_bank.sv
`timescale 1ns/1ps
module smb_reg_bank #(
  parameter int                    NUM_REGS = 8,
  parameter int                    IDX_W    = 3,
  parameter logic [NUM_REGS*8-1:0] RST_VAL  = '1,
  parameter logic [NUM_REGS*8-1:0] RSV_MASK = '0,
  parameter logic [NUM_REGS*8-1:0] RSV_VAL  = '0,
  parameter int                    STOP_REG = 0,
  parameter int                    STOP_BIT = 2,
  parameter int                    STAT_REG = 0,
  parameter int                    STAT_BIT = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [IDX_W-1:0]        widx_i,
  input  logic [7:0]              wdata_i,
  input  logic [IDX_W-1:0]        ridx_i,
  input  logic                    stop_ni,
  output logic [7:0]              rdata_o,
  output logic [NUM_REGS*8-1:0]   regs_o
);
  localparam logic [NUM_REGS*8-1:0] STAT_ONE =
    {{(NUM_REGS*8-1){1'b0}}, 1'b1} << (STAT_REG*8 + STAT_BIT);
  localparam logic [NUM_REGS*8-1:0] FIX_MASK = RSV_MASK | STAT_ONE;

  logic [7:0] reg_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] M = FIX_MASK[g*8 +: 8];
    localparam logic [7:0] V = RSV_VAL[g*8 +: 8] & FIX_MASK[g*8 +: 8];
    localparam logic [7:0] R = RST_VAL[g*8 +: 8];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                reg_q[g] <= (R & ~M) | V;
      else if (we_i && widx_i == IDX_W'(g))       reg_q[g] <= (wdata_i & ~M) | V;
    end

    assign regs_o[g*8 +: 8] = reg_q[g];
  end

  always_comb begin
    rdata_o = reg_q[ridx_i];
    if (ridx_i == IDX_W'(STAT_REG))
      rdata_o[STAT_BIT] = reg_q[STOP_REG][STOP_BIT] & stop_ni;
  end
endmodule

// File: rtl/smb_cfg_slave.sv
`timescale 1ns/1ps
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter int                    NUM_REGS    = 8,
  parameter logic [6:0]            DEV_ADDR    = 7'h69,
  parameter int                    SYNC_STAGES = 2,
  parameter logic [NUM_REGS*8-1:0] RST_VAL     = '1,
  parameter logic [NUM_REGS*8-1:0] RSV_MASK    = 64'h0000_0000_0003_4088,
  parameter logic [NUM_REGS*8-1:0] RSV_VAL     = 64'h0000_0000_0000_4000,
  parameter int                    STOP_REG    = 0,
  parameter int                    STOP_BIT    = 2,
  parameter int                    STAT_REG    = 0,
  parameter int                    STAT_BIT    = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  pci_stop_ni,
  output logic                  sda_pull_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic scl_s, sda_s;
  logic start_ev, stop_ev, scl_rise, scl_fall;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_s)
  );
  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s)
  );

  smb_bus_events u_events (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_s),
    .sda_i     (sda_s),
    .start_o   (start_ev),
    .stop_o    (stop_ev),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall)
  );

  smb_state_e       st;
  smb_role_e        role;
  logic [7:0]       shreg;
  logic [3:0]       bcnt;
  logic             pull;
  logic [IDX_W-1:0] idx;
  logic             blk_mode;
  logic [7:0]       remain;
  logic             go_tx;
  logic             cnt_pend;
  logic             mack;

  logic       rx_done, rx_ack, wr_en, ld_tx;
  logic [7:0] rd_data, tx_byte;

  smb_reg_bank #(
    .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .RST_VAL(RST_VAL),
    .RSV_MASK(RSV_MASK), .RSV_VAL(RSV_VAL),
    .STOP_REG(STOP_REG), .STOP_BIT(STOP_BIT),
    .STAT_REG(STAT_REG), .STAT_BIT(STAT_BIT)
  ) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en),
    .widx_i (idx),
    .wdata_i(shreg),
    .ridx_i (idx),
    .stop_ni(pci_stop_ni),
    .rdata_o(rd_data),
    .regs_o (regs_o)
  );

  always_comb begin
    rx_done = (st == S_RX) && scl_fall && (bcnt == 4'd8);
    unique case (role)
      ROLE_ADDR: rx_ack = (shreg[7:1] == DEV_ADDR);
      ROLE_DATA: rx_ack = (remain != 8'd0);
      default:   rx_ack = 1'b1;
    endcase
    // commit only a fully received data byte that was accepted
    wr_en   = rx_done && (role == ROLE_DATA) && (remain != 8'd0);
    tx_byte = cnt_pend ? 8'(NUM_REGS) : rd_data;
    ld_tx   = scl_fall && (((st == S_RX_ACK) && go_tx) || ((st == S_TX_ACK) && mack));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= S_IDLE;
      role     <= ROLE_ADDR;
      shreg    <= '0;
      bcnt     <= '0;
      pull     <= 1'b0;
      idx      <= '0;
      blk_mode <= 1'b1;
      remain   <= '0;
      go_tx    <= 1'b0;
      cnt_pend <= 1'b0;
      mack     <= 1'b0;
    end else if (start_ev) begin
      st    <= S_RX;
      role  <= ROLE_ADDR;
      bcnt  <= '0;
      pull  <= 1'b0;
      go_tx <= 1'b0;
    end else if (stop_ev) begin
      st   <= S_IDLE;
      pull <= 1'b0;
    end else if (ld_tx) begin
      shreg <= tx_byte;
      pull  <= ~tx_byte[7];
      bcnt  <= '0;
      st    <= S_TX;
      if (cnt_pend)      cnt_pend <= 1'b0;
      else if (blk_mode) idx      <= idx + 1'b1;
    end else begin
      unique case (st)
        S_RX: begin
          if (scl_rise && bcnt != 4'd8) begin
            shreg <= {shreg[6:0], sda_s};
            bcnt  <= bcnt + 4'd1;
          end else if (rx_done) begin
            if (rx_ack) begin
              pull <= 1'b1;
              st   <= S_RX_ACK;
              unique case (role)
                ROLE_ADDR: begin
                  go_tx    <= shreg[0];
                  cnt_pend <= shreg[0] & blk_mode;
                  role     <= ROLE_CMD;
                end
                ROLE_CMD: begin
                  blk_mode <= ~shreg[7];
                  idx      <= shreg[IDX_W-1:0];
                  remain   <= 8'd1;
                  role     <= shreg[7] ? ROLE_DATA : ROLE_CNT;
                end
                ROLE_CNT: begin
                  remain <= shreg;
                  role   <= ROLE_DATA;
                end
                default: begin
                  remain <= remain - 8'd1;
                  if (blk_mode) idx <= idx + 1'b1;
                end
              endcase
            end else begin
              st <= S_SKIP;
            end
          end
        end
        S_RX_ACK: if (scl_fall) begin
          pull <= 1'b0;
          bcnt <= '0;
          st   <= S_RX;
        end
        S_TX: if (scl_fall) begin
          if (bcnt == 4'd7) begin
            pull <= 1'b0;
            st   <= S_TX_ACK;
          end else begin
            shreg <= {shreg[6:0], 1'b0};
            pull  <= ~shreg[6];
            bcnt  <= bcnt + 4'd1;
          end
        end
        S_TX_ACK: begin
          if (scl_rise)      mack <= ~sda_s;
          else if (scl_fall) st   <= S_SKIP;
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o = pull;
endmodule

// File: rtl/smb_cfg_slave_chk.sv
`timescale 1ns/1ps
module smb_cfg_slave_chk #(
  parameter int              W        = 64,
  parameter logic [W-1:0]    RSV_MASK = '0,
  parameter logic [W-1:0]    RSV_VAL  = '0
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         scl_s_i,
  input logic         start_i,
  input logic         stop_i,
  input logic         idle_i,
  input logic         pull_i,
  input logic [W-1:0] regs_i
);
  // R12
  pull_on_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_i) |-> !scl_s_i);

  // R2
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !pull_i);

  // R2
  start_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !pull_i);

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> !pull_i);

  // R9
  fixed_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((regs_i ^ RSV_VAL) & RSV_MASK) == '0);
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(
  .W(NUM_REGS*8), .RSV_MASK(RSV_MASK), .RSV_VAL(RSV_VAL)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .scl_s_i(scl_s),
  .start_i(start_ev),
  .stop_i (stop_ev),
  .idle_i (st == smb_cfg_pkg::S_IDLE),
  .pull_i (sda_pull_o),
  .regs_i (regs_o)
);

// File: tb/smb_cfg_slave_test.sv
`timescale 1ns/1ps
module smb_cfg_slave_test;
  localparam int QTR = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        stop_n = 1'b1;
  logic        sda_pull;
  logic        sda_w;
  logic [63:0] regs;

  always #2.5 clk = ~clk;
  assign sda_w = sda_m & ~sda_pull;

  smb_cfg_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_w),
    .pci_stop_ni(stop_n), .sda_pull_o(sda_pull), .regs_o(regs)
  );

  int errs = 0, checks = 0;
  bit done = 0;
  logic [7:0] exp_r [8];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];
  bit         abuf [16];
  bit         hdr_ok;

  function automatic logic [7:0] fix_m(int i);
    case (i) 0: return 8'h88; 1: return 8'h40; 2: return 8'h03; default: return 8'h00; endcase
  endfunction
  function automatic logic [7:0] fix_v(int i);
    return (i == 1) ? 8'h40 : 8'h00;
  endfunction
  task automatic model_wr(int i, logic [7:0] v);
    exp_r[i] = (v & ~fix_m(i)) | fix_v(i);
  endtask
  function automatic logic [7:0] exp_rd(int i);
    logic [7:0] v = exp_r[i];
    if (i == 0) v[3] = exp_r[0][2] & stop_n;
    return v;
  endfunction
  function automatic logic [63:0] exp_pack();
    logic [63:0] p;
    for (int i = 0; i < 8; i++) p[i*8 +: 8] = exp_r[i];
    return p;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic q();
    repeat (QTR) @(negedge clk);
  endtask
  task automatic bus_start();
    sda_m = 1; q(); scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q();
  endtask
  task automatic bus_stop();
    sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q();
  endtask
  task automatic wbit(bit b);
    sda_m = b; q(); scl_m = 1; q(); q(); scl_m = 0; q();
  endtask
  task automatic rbit(output bit b);
    sda_m = 1; q(); scl_m = 1; q(); b = sda_w; q(); scl_m = 0; q();
  endtask
  task automatic wbyte(logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = !b;
  endtask
  task automatic rbyte(output logic [7:0] d, input bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(!ack);
  endtask

  task automatic wr_byte(int idx, logic [7:0] v, output bit dack);
    bit a0, a1;
    bus_start(); wbyte(8'hD2, a0); wbyte({1'b1, 7'(idx)}, a1); wbyte(v, dack); bus_stop();
    hdr_ok = a0 & a1;
  endtask
  task automatic rd_byte(int idx, output logic [7:0] v);
    bit a0, a1, a2;
    bus_start(); wbyte(8'hD2, a0); wbyte({1'b1, 7'(idx)}, a1);
    bus_start(); wbyte(8'hD3, a2); rbyte(v, 1'b0); bus_stop();
    hdr_ok = a0 & a1 & a2;
  endtask
  task automatic wr_blk(int idx, int cnt, int n);
    bit a0, a1, a2;
    bus_start(); wbyte(8'hD2, a0); wbyte({1'b0, 7'(idx)}, a1); wbyte(8'(cnt), a2);
    for (int i = 0; i < n; i++) wbyte(wbuf[i], abuf[i]);
    bus_stop();
    hdr_ok = a0 & a1 & a2;
  endtask
  task automatic rd_blk(int idx, int n, output logic [7:0] cnt);
    bit a0, a1, a2;
    bus_start(); wbyte(8'hD2, a0); wbyte({1'b0, 7'(idx)}, a1);
    bus_start(); wbyte(8'hD3, a2); rbyte(cnt, 1'b1);
    for (int i = 0; i < n; i++) rbyte(rbuf[i], i < n - 1);
    bus_stop();
    hdr_ok = a0 & a1 & a2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] v, c;
    bit a, a2;
    void'($urandom(32'h1c0de));
    for (int i = 0; i < 8; i++) model_wr(i, 8'hFF);
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R11 reset state on the ports and on the bus
    chk(regs == exp_pack(), "R11 regs_o after reset", regs, exp_pack());
    chk(sda_pull == 0, "R11 sda released after reset", sda_pull, 0);
    rd_blk(0, 8, c);
    chk(hdr_ok, "R12 header acks block read", hdr_ok, 1);
    chk(c == 8'd8, "R6 block read count", c, 8);
    for (int i = 0; i < 8; i++)
      chk(rbuf[i] == exp_rd(i), $sformatf("R11 reset reg%0d", i), rbuf[i], exp_rd(i));

    // R1 wrong address is not acknowledged, nothing changes
    bus_start(); wbyte(8'hA4, a); wbyte(8'h85, a2); wbyte(8'h00, a2); bus_stop();
    chk(!a, "R1 foreign address acked", a, 0);
    chk(!a2, "R1 byte after foreign address acked", a2, 0);
    bus_start(); wbyte(8'hD0, a); bus_stop();
    chk(!a, "R1 near address acked", a, 0);
    chk(regs == exp_pack(), "R1 regs changed", regs, exp_pack());

    // R5 R7 byte write and read
    wr_byte(5, 8'h3C, a); model_wr(5, 8'h3C);
    chk(hdr_ok && a, "R12 byte write acks", {hdr_ok, a}, 3);
    rd_byte(5, v);
    chk(v == exp_rd(5), "R7 byte read reg5", v, exp_rd(5));
    bus_start(); wbyte(8'hD2, a); wbyte(8'h86, a); wbyte(8'h11, a); wbyte(8'h22, a2); bus_stop();
    model_wr(6, 8'h11);
    chk(a && !a2, "R5 second data byte", {a, a2}, 2);
    chk(regs == exp_pack(), "R5 regs after extra byte", regs, exp_pack());

    // R3 index folds modulo 8
    wr_byte(8'h0D, 8'hA5, a); model_wr(5, 8'hA5);
    chk(regs[47:40] == 8'hA5, "R3 index 0x0D lands on reg5", regs[47:40], 8'hA5);

    // R4 block write with wrap and excess byte
    wbuf[0] = 8'h12; wbuf[1] = 8'h34; wbuf[2] = 8'h56; wbuf[3] = 8'h7B; wbuf[4] = 8'h9A;
    wr_blk(6, 4, 5);
    model_wr(6, 8'h12); model_wr(7, 8'h34); model_wr(0, 8'h56); model_wr(1, 8'h7B);
    chk(abuf[0] && abuf[1] && abuf[2] && abuf[3], "R4 counted bytes acked",
        {abuf[0], abuf[1], abuf[2], abuf[3]}, 4'hF);
    chk(!abuf[4], "R4 excess byte acked", abuf[4], 0);
    chk(regs == exp_pack(), "R4 regs after block write", regs, exp_pack());
    rd_blk(6, 4, c);
    for (int i = 0; i < 4; i++)
      chk(rbuf[i] == exp_rd((6 + i) % 8), "R6 block read wrap", rbuf[i], exp_rd((6 + i) % 8));

    // R9 fixed bits
    wr_byte(1, 8'h00, a); model_wr(1, 8'h00);
    rd_byte(1, v);
    chk(v == 8'h40, "R9 reg1 bit6 stuck at 1", v, 8'h40);
    wr_byte(2, 8'hFF, a); model_wr(2, 8'hFF);
    rd_byte(2, v);
    chk(v == 8'hFC, "R9 reg2 low bits stuck at 0", v, 8'hFC);

    // R10 status bit
    wr_byte(0, 8'hFF, a); model_wr(0, 8'hFF);
    rd_byte(0, v);
    chk(v == 8'h7F, "R10 status running", v, 8'h7F);
    wr_byte(0, 8'hFB, a); model_wr(0, 8'hFB);
    rd_byte(0, v);
    chk(v == 8'h73, "R10 status with stop bit", v, 8'h73);
    wr_byte(0, 8'hFF, a); model_wr(0, 8'hFF);
    stop_n = 0;
    rd_byte(0, v);
    chk(v == 8'h77, "R10 status with stop pin", v, 8'h77);
    stop_n = 1;
    chk(regs[7:0] == 8'h77, "R10 status held 0 in regs_o", regs[7:0], 8'h77);

    // R2 stop inside a byte aborts
    bus_start(); wbyte(8'hD2, a); wbyte(8'h03, a); wbyte(8'h02, a); wbyte(8'h5A, a);
    wbit(1); wbit(0); wbit(0); wbit(1);
    bus_stop();
    model_wr(3, 8'h5A);
    chk(regs == exp_pack(), "R2 partial byte written", regs, exp_pack());
    wr_byte(4, 8'h66, a); model_wr(4, 8'h66);
    chk(a && regs[39:32] == 8'h66, "R2 transfer after abort", regs[39:32], 8'h66);

    // R8 host NACK ends transmission
    bus_start(); wbyte(8'hD2, a); wbyte(8'h84, a); bus_start(); wbyte(8'hD3, a);
    rbyte(v, 1'b0); rbyte(c, 1'b1); bus_stop();
    chk(v == exp_rd(4), "R8 first byte", v, exp_rd(4));
    chk(c == 8'hFF, "R8 line released after nack", c, 8'hFF);

    // random traffic
    for (int it = 0; it < 14; it++) begin
      int idx = $urandom_range(0, 7);
      int n   = $urandom_range(1, 4);
      if ($urandom_range(0, 1)) begin
        v = 8'($urandom());
        wr_byte(idx + 8 * $urandom_range(0, 15), v, a); model_wr(idx, v);
        chk(a, "R5 random byte write ack", a, 1);
      end else begin
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom());
        wr_blk(idx, n, n);
        for (int i = 0; i < n; i++) model_wr((idx + i) % 8, wbuf[i]);
      end
      if ($urandom_range(0, 1)) begin
        rd_byte(idx, v);
        chk(v == exp_rd(idx), "R7 random byte read", v, exp_rd(idx));
      end else begin
        rd_blk(idx, n, c);
        for (int i = 0; i < n; i++)
          chk(rbuf[i] == exp_rd((idx + i) % 8), "R4 random block data", rbuf[i], exp_rd((idx + i) % 8));
      end
    end
    chk(regs == exp_pack(), "R4 regs after random traffic", regs, exp_pack());

    finish_run();
  end
endmodule